// File: doc/BRIEF.md
# Byte Pack/Unpack Staging Buffer

This block stages data between a byte-wide peripheral path and a word-wide memory path. When it packs, incoming peripheral bytes are placed into the byte lane named by the low address bits. Lane 0 is the most significant byte. When the byte for the last lane arrives, the buffer issues a full-word write on its own. When it unpacks, it takes a fetched memory word and hands its bytes to the peripheral one at a time, starting at the current lane.

A drain command writes out a partly filled word. The write enables only the lanes that hold bytes. Software uses drain after a transfer into memory. A flush command discards the held bytes and also clears the sticky error and terminal-count flags. Software uses flush after a transfer out of memory. A status word reports how many bytes the buffer holds and which lane comes next. Both commands show as pending bits that clear themselves.

Top module: `pkb_buffer`

## Requirements
- R1: After reset, `stat` is 0 and `wr_valid` is low. With `dir_pack` low, `need_word` is high.
- R2: While packing, each accepted byte goes into lane L, which is data bits [31-8L:24-8L]. Write-enable bit 3-L covers that lane. After each accepted byte, the count field `stat[4:2]` rises by one and the lane field `stat[12:11]` advances by one.
- R3: Accepting a byte into lane 3 produces a one-cycle write on the next cycle. That write enables every lane from the first held byte through lane 3. The same edge returns the count and the lane field to 0.
- R4: A drain request sets pending bit `stat[5]`. One cycle later, in the pack direction, the held bytes are written with enables for the occupied lanes only. The count then clears, the lane field is unchanged, and the pending bit clears. An empty buffer produces no write.
- R5: A flush request sets pending bit `stat[6]`. One cycle later, the held bytes are discarded without a write. The count, the error flag `stat[0]` and the terminal-count flag `stat[1]` are cleared, and the pending bit clears.
- R6: Bytes, words and take strobes that arrive while a drain or flush is pending are ignored.
- R7: While unpacking, a word arriving with count 0 is loaded, and the count becomes 4 minus the lane. `rd_byte` shows the current lane, and each take advances the lane and lowers the count. A word arriving while the count is nonzero is ignored. `need_word` is high only when the count is 0.
- R8: `err_hit` sets `stat[0]` and `tc_hit` sets `stat[1]`. Both flags stay set until a flush.
- R9: A lane load sets the lane field to `lane_init`, clears the count and empties the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dir_pack | input | 1 | 1: peripheral to memory (pack), 0: memory to peripheral (unpack) |
| lane_load | input | 1 | Load the starting lane |
| lane_init | input | 2 | Low address bits of the first byte |
| pbyte_valid | input | 1 | Peripheral byte present (pack) |
| pbyte_data | input | 8 | Peripheral byte |
| word_valid | input | 1 | Fetched memory word present (unpack) |
| word_data | input | 32 | Fetched memory word |
| byte_take | input | 1 | Peripheral consumes `rd_byte` (unpack) |
| drain_req | input | 1 | Drain command pulse |
| flush_req | input | 1 | Flush command pulse |
| err_hit | input | 1 | Sets the error flag |
| tc_hit | input | 1 | Sets the terminal-count flag |
| wr_valid | output | 1 | One-cycle memory word write |
| wr_data | output | 32 | Write data |
| wr_be | output | 4 | Write byte enables, bit 3 = lane 0 |
| rd_byte | output | 8 | Byte at the current lane (unpack) |
| need_word | output | 1 | Buffer empty in unpack direction |
| stat | output | 16 | Status: flags, count, pending bits, lane |

## Verification
Packing is driven from lane 0, which gives a full four-byte word, and from lane 2, which gives a two-lane tail word. Together they separate lane steering from enable-mask generation. Draining a two-byte run that starts in lane 1 shows whether the enables follow both the start lane and the count, and a drain of an empty buffer must produce no write. A flush between bytes shows that the discarded lane comes back as zero data with its enable off. Unpack words are loaded at lanes 0 and 2, and an extra word is offered while the buffer is full, to separate the count arithmetic from the rule that blocks a reload.

// File: rtl/pkb_pkg.sv
`timescale 1ns/1ps
package pkb_pkg;
    localparam int DEF_BYTE_W = 8;
    localparam int DEF_LANES  = 4;
    localparam int STAT_W     = 16;
    localparam int ERR_BIT    = 0;
    localparam int TC_BIT     = 1;
    localparam int CNT_LSB    = 2;
    localparam int DRN_BIT    = 5;
    localparam int FLS_BIT    = 6;
    localparam int LANE_LSB   = 11;
endpackage

// File: rtl/pkb_lane_ins.sv
`timescale 1ns/1ps
// Replaces the byte of one lane in a word; lane 0 is the most significant byte.
module pkb_lane_ins #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 4
) (
    input  logic [BYTE_W*LANES-1:0]     word_i,
    input  logic [$clog2(LANES)-1:0]    lane_i,
    input  logic [BYTE_W-1:0]           byte_i,
    output logic [BYTE_W*LANES-1:0]     word_o
);
    localparam int WORD_W = BYTE_W * LANES;
    localparam int LANE_W = $clog2(LANES);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign word_o[WORD_W-1-i*BYTE_W -: BYTE_W] =
            (lane_i == LANE_W'(i)) ? byte_i : word_i[WORD_W-1-i*BYTE_W -: BYTE_W];
    end
endmodule

// File: rtl/pkb_lane_pick.sv
`timescale 1ns/1ps
// Selects the byte of one lane from a word.
module pkb_lane_pick #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 4
) (
    input  logic [BYTE_W*LANES-1:0]     word_i,
    input  logic [$clog2(LANES)-1:0]    lane_i,
    output logic [BYTE_W-1:0]           byte_o
);
    localparam int WORD_W = BYTE_W * LANES;
    localparam int LANE_W = $clog2(LANES);

    always_comb begin
        byte_o = '0;
        for (int i = 0; i < LANES; i++) begin
            if (lane_i == LANE_W'(i)) byte_o = word_i[WORD_W-1-i*BYTE_W -: BYTE_W];
        end
    end
endmodule

// File: rtl/pkb_lane_mask.sv
`timescale 1ns/1ps
// Byte enables for a run of lanes; enable bit LANES-1-i covers lane i.
module pkb_lane_mask #(
    parameter int LANES = 4
) (
    input  logic [$clog2(LANES)-1:0]    first_i,
    input  logic [$clog2(LANES+1)-1:0]  cnt_i,
    output logic [LANES-1:0]            be_o
);
    always_comb begin
        be_o = '0;
        for (int i = 0; i < LANES; i++) begin
            be_o[LANES-1-i] = (i >= int'(first_i)) && (i < int'(first_i) + int'(cnt_i));
        end
    end
endmodule

// File: rtl/pkb_flags.sv
`timescale 1ns/1ps
// Sticky error and terminal-count flags; a clear wins over a set.
module pkb_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic err_set,
    input  logic tc_set,
    input  logic clr,
    output logic err_o,
    output logic tc_o
);
    typedef struct packed {
        logic err;
        logic tc;
    } flg_t;

    flg_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (clr) begin
            f_d = '0;
        end else begin
            f_d.err = f_q.err | err_set;
            f_d.tc  = f_q.tc | tc_set;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign err_o = f_q.err;
    assign tc_o  = f_q.tc;
endmodule

// File: rtl/pkb_buffer.sv
`timescale 1ns/1ps
module pkb_buffer
    import pkb_pkg::*;
#(
    parameter int BYTE_W = DEF_BYTE_W,
    parameter int LANES  = DEF_LANES
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           dir_pack,
    input  logic                           lane_load,
    input  logic [$clog2(LANES)-1:0]       lane_init,
    input  logic                           pbyte_valid,
    input  logic [BYTE_W-1:0]              pbyte_data,
    input  logic                           word_valid,
    input  logic [BYTE_W*LANES-1:0]        word_data,
    input  logic                           byte_take,
    input  logic                           drain_req,
    input  logic                           flush_req,
    input  logic                           err_hit,
    input  logic                           tc_hit,
    output logic                           wr_valid,
    output logic [BYTE_W*LANES-1:0]        wr_data,
    output logic [LANES-1:0]               wr_be,
    output logic [BYTE_W-1:0]              rd_byte,
    output logic                           need_word,
    output logic [STAT_W-1:0]              stat
);
    localparam int WORD_W = BYTE_W * LANES;
    localparam int LANE_W = $clog2(LANES);
    localparam int CNT_W  = $clog2(LANES + 1);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [LANE_W-1:0] lane;
        logic [LANE_W-1:0] first;
        logic [CNT_W-1:0]  cnt;
        logic              drain;
        logic              flush;
        logic              wr_v;
        logic [WORD_W-1:0] wr_d;
        logic [LANES-1:0]  wr_be;
    } st_t;

    st_t s_d, s_q;

    logic [WORD_W-1:0] word_ins;
    logic [LANE_W-1:0] mask_first;
    logic [CNT_W-1:0]  mask_cnt;
    logic [LANES-1:0]  mask_be;
    logic              last_lane;
    logic              err_f, tc_f;

    pkb_lane_ins #(.BYTE_W(BYTE_W), .LANES(LANES)) u_ins (
        .word_i (s_q.word),
        .lane_i (s_q.lane),
        .byte_i (pbyte_data),
        .word_o (word_ins)
    );

    pkb_lane_pick #(.BYTE_W(BYTE_W), .LANES(LANES)) u_pick (
        .word_i (s_q.word),
        .lane_i (s_q.lane),
        .byte_o (rd_byte)
    );

    pkb_lane_mask #(.LANES(LANES)) u_mask (
        .first_i (mask_first),
        .cnt_i   (mask_cnt),
        .be_o    (mask_be)
    );

    pkb_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .err_set (err_hit),
        .tc_set  (tc_hit),
        .clr     (s_q.flush),
        .err_o   (err_f),
        .tc_o    (tc_f)
    );

    assign last_lane = (s_q.lane == LANE_W'(LANES - 1));

    // Enable run: held bytes for a drain, held bytes plus the incoming one otherwise.
    always_comb begin
        if (s_q.drain) begin
            mask_first = s_q.first;
            mask_cnt   = s_q.cnt;
        end else begin
            mask_first = (s_q.cnt == '0) ? s_q.lane : s_q.first;
            mask_cnt   = s_q.cnt + CNT_W'(1);
        end
    end

    always_comb begin
        s_d       = s_q;
        s_d.wr_v  = 1'b0;
        s_d.wr_be = '0;
        s_d.drain = drain_req & ~s_q.drain & ~s_q.flush;
        s_d.flush = flush_req & ~s_q.flush;

        if (s_q.flush) begin
            s_d.word = '0;
            s_d.cnt  = '0;
        end else if (s_q.drain) begin
            if (dir_pack) begin
                if (s_q.cnt != '0) begin
                    s_d.wr_v  = 1'b1;
                    s_d.wr_d  = s_q.word;
                    s_d.wr_be = mask_be;
                end
                s_d.word = '0;
                s_d.cnt  = '0;
            end
        end else if (lane_load) begin
            s_d.word  = '0;
            s_d.cnt   = '0;
            s_d.lane  = lane_init;
            s_d.first = lane_init;
        end else if (dir_pack) begin
            if (pbyte_valid) begin
                if (s_q.cnt == '0) s_d.first = s_q.lane;
                s_d.lane = s_q.lane + LANE_W'(1);
                if (last_lane) begin
                    s_d.wr_v  = 1'b1;
                    s_d.wr_d  = word_ins;
                    s_d.wr_be = mask_be;
                    s_d.word  = '0;
                    s_d.cnt   = '0;
                end else begin
                    s_d.word = word_ins;
                    s_d.cnt  = s_q.cnt + CNT_W'(1);
                end
            end
        end else begin
            if (word_valid && s_q.cnt == '0) begin
                s_d.word = word_data;
                s_d.cnt  = CNT_W'(LANES) - CNT_W'(s_q.lane);
            end else if (byte_take && s_q.cnt != '0) begin
                s_d.lane = s_q.lane + LANE_W'(1);
                s_d.cnt  = s_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wr_valid  = s_q.wr_v;
    assign wr_data   = s_q.wr_d;
    assign wr_be     = s_q.wr_be;
    assign need_word = ~dir_pack & (s_q.cnt == '0) & ~s_q.drain & ~s_q.flush;

    always_comb begin
        stat                        = '0;
        stat[ERR_BIT]               = err_f;
        stat[TC_BIT]                = tc_f;
        stat[CNT_LSB +: CNT_W]      = s_q.cnt;
        stat[DRN_BIT]               = s_q.drain;
        stat[FLS_BIT]               = s_q.flush;
        stat[LANE_LSB +: LANE_W]    = s_q.lane;
    end
endmodule

// File: rtl/pkb_chk.sv
`timescale 1ns/1ps
module pkb_chk
    import pkb_pkg::*;
#(
    parameter int LANES = DEF_LANES
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic [LANES-1:0]  wr_be,
    input logic [STAT_W-1:0] stat,
    input logic              need_word
);
    localparam int CNT_W = $clog2(LANES + 1);

    // R3
    wr_be_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_be != '0));

    // R3
    wr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (stat[CNT_LSB +: CNT_W] == '0));

    // R4
    drain_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat[DRN_BIT] |=> !stat[DRN_BIT]);

    // R5
    flush_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat[FLS_BIT] |=> (stat[CNT_LSB +: CNT_W] == '0) && !stat[ERR_BIT] && !stat[TC_BIT]
                          && !stat[FLS_BIT] && !wr_valid);

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(stat[CNT_LSB +: CNT_W]) <= LANES);

    // R7
    need_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        need_word |-> (stat[CNT_LSB +: CNT_W] == '0));
endmodule

bind pkb_buffer pkb_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_be     (wr_be),
    .stat      (stat),
    .need_word (need_word)
);

// File: tb/pkb_buffer_test.sv
`timescale 1ns/1ps
module pkb_buffer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dir_pack = 1'b0, lane_load = 1'b0;
    logic [1:0]  lane_init = '0;
    logic        pbyte_valid = 1'b0;
    logic [7:0]  pbyte_data = '0;
    logic        word_valid = 1'b0;
    logic [31:0] word_data = '0;
    logic        byte_take = 1'b0, drain_req = 1'b0, flush_req = 1'b0;
    logic        err_hit = 1'b0, tc_hit = 1'b0;
    logic        wr_valid, need_word;
    logic [31:0] wr_data;
    logic [3:0]  wr_be;
    logic [7:0]  rd_byte;
    logic [15:0] stat;

    int    errs = 0;
    int    checks = 0;
    bit    done = 1'b0;
    logic [35:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    pkb_buffer uut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_wr(input string req, input logic [31:0] d, input logic [3:0] be);
        exp_q.push_back({be, d});
        tag_q.push_back(req);
    endtask

    task automatic load_lane(input logic [1:0] l);
        lane_load = 1'b1; lane_init = l; step(); lane_load = 1'b0;
    endtask

    task automatic push_byte(input logic [7:0] b);
        pbyte_valid = 1'b1; pbyte_data = b; step(); pbyte_valid = 1'b0;
    endtask

    // Scoreboard monitor for memory writes
    always @(negedge clk) begin
        if (rst_n && wr_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errs++;
                $display("FAIL R4 unexpected write act=%h/%b exp=none", wr_data, wr_be);
            end else begin
                logic [35:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({wr_be, wr_data} !== e) begin
                    errs++;
                    $display("FAIL %s write act=%h/%b exp=%h/%b", t, wr_data, wr_be, e[31:0], e[35:32]);
                end
            end
        end
    end

    initial begin
        #(20000 * 4);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL R1 watchdog act=running exp=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();
        check("R1 stat", stat, 32'h0);
        check("R1 wr_valid", wr_valid, 32'h0);
        check("R1 need_word", need_word, 32'h1);

        // Pack, full word from lane 0
        dir_pack = 1'b1;
        load_lane(2'd0);
        expect_wr("R3 full word", 32'h11223344, 4'b1111);
        push_byte(8'h11);
        push_byte(8'h22);
        check("R2 count/lane after two", stat, 32'h1008);
        push_byte(8'h33);
        push_byte(8'h44);
        check("R3 stat after auto write", stat, 32'h0);

        // Pack, tail word from lane 2
        load_lane(2'd2);
        check("R9 lane load", stat, 32'h1000);
        expect_wr("R3 tail word", 32'h0000AABB, 4'b0011);
        push_byte(8'hAA);
        check("R2 lane2 byte", stat, 32'h1804);
        push_byte(8'hBB);
        check("R3 wrap to lane 0", stat, 32'h0);

        // Partial drain from lane 1
        load_lane(2'd1);
        push_byte(8'hCC);
        push_byte(8'hDD);
        check("R2 two bytes from lane1", stat, 32'h1808);
        expect_wr("R4 partial drain", 32'h00CCDD00, 4'b0110);
        drain_req = 1'b1; step(); drain_req = 1'b0;
        check("R4 drain pending", stat, 32'h1828);
        step();
        check("R4 after drain", stat, 32'h1800);

        // Empty drain: no write
        drain_req = 1'b1; step(); drain_req = 1'b0;
        step();
        check("R4 empty drain", stat, 32'h1800);

        // Flush discards and clears flags
        load_lane(2'd0);
        push_byte(8'h5A);
        err_hit = 1'b1; tc_hit = 1'b1; step(); err_hit = 1'b0; tc_hit = 1'b0;
        step();
        check("R8 sticky flags", stat, 32'h0807);
        flush_req = 1'b1; step(); flush_req = 1'b0;
        check("R5 flush pending", stat, 32'h0847);
        step();
        check("R5 after flush", stat, 32'h0800);
        expect_wr("R5 flushed lane empty", 32'h00010203, 4'b0111);
        push_byte(8'h01);
        push_byte(8'h02);
        push_byte(8'h03);
        check("R3 after post-flush word", stat, 32'h0);

        // Byte ignored while drain pending
        load_lane(2'd0);
        push_byte(8'h77);
        expect_wr("R6 drain with ignored byte", 32'h77000000, 4'b1000);
        drain_req = 1'b1; step(); drain_req = 1'b0;
        push_byte(8'h99);
        check("R6 byte ignored", stat, 32'h0800);

        // Unpack
        dir_pack = 1'b0;
        load_lane(2'd0);
        check("R7 need word", need_word, 32'h1);
        word_valid = 1'b1; word_data = 32'hA1B2C3D4; step();
        word_data = 32'h11111111; step(); word_valid = 1'b0;
        check("R7 loaded count", stat, 32'h0010);
        check("R7 first byte kept", rd_byte, 32'hA1);
        check("R7 need low", need_word, 32'h0);
        byte_take = 1'b1; step(); byte_take = 1'b0;
        check("R7 second byte", rd_byte, 32'hB2);
        check("R7 stat after take", stat, 32'h080C);
        byte_take = 1'b1; step(); byte_take = 1'b0;
        check("R7 third byte", rd_byte, 32'hC3);
        byte_take = 1'b1; step(); step(); byte_take = 1'b0;
        check("R7 emptied", stat, 32'h0);
        check("R7 need again", need_word, 32'h1);
        load_lane(2'd2);
        word_valid = 1'b1; word_data = 32'hE0E1E2E3; step(); word_valid = 1'b0;
        check("R7 load at lane2", stat, 32'h1008);
        check("R7 lane2 byte", rd_byte, 32'hE2);

        repeat (3) step();
        check("R3 all writes seen", exp_q.size(), 32'h0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule